// File: doc/BRIEF.md
# I2C Target Address-Matching Receiver

This block is the target (slave) side of a two-wire I2C link with a 7-bit address, clocked from the local system clock. It brings the clock and data lines in through synchronizers and spots start and stop conditions on them. After each start it collects an address byte and compares its upper seven bits with a programmed own address. When general-call acceptance is on, it also takes the all-zero address. On a hit it pulls the data line low for the acknowledge clock. From then on it either collects bytes written by the controller into a one-entry receive buffer, or sends bytes that software loads for a read.

Software sees a set of status outputs. These report whether the last byte handled was an address or data, which bus condition came last, the transfer direction, and whether the receive buffer is full or has overflowed. A one-cycle event pulse marks each address hit and each data byte. A clock-release control lets software keep the clock line low while the target is addressed. In a read, the block also stretches the clock by itself until the next transmit byte has been loaded.

Top module: `i2c_addr_target`

## Requirements
- R1: After reset both line drivers (`scl_oe`, `sda_oe`) are off and `rx_data`, `buf_full`, `buf_ovf`, `st_data`, `st_start`, `st_stop`, `st_rw` and `evt` are all 0.
- R2: A falling data line while the clock line is high is a start. It sets `st_start` and clears `st_stop`. A rising data line while the clock line is high is a stop. It sets `st_stop` and clears `st_start`. The two flags are never 1 together.
- R3: The first byte after a start is taken MSB first. Bits 7..1 are the address and bit 0 is the direction, where 1 means read. If the address equals `own_addr`, the target drives SDA low during the ninth clock. Otherwise it never drives SDA until the next start.
- R4: The address 0 is acknowledged when `gc_en` is 1 and ignored when `gc_en` is 0 (given a nonzero `own_addr`).
- R5: `st_data` is 0 after an address hit and 1 after a data byte is received or transmitted.
- R6: `st_rw` takes the direction bit on an address hit. It returns to 0 on the next start (including a repeated start), on a stop, or when the controller does not acknowledge a transmitted byte.
- R7: In a write, each completed data byte with `buf_full` at 0 is copied to `rx_data` and sets `buf_full`, and the target acknowledges it. A one-cycle `rd_strobe` clears `buf_full`.
- R8: A data byte that completes while `buf_full` is 1 sets `buf_ovf`, leaves `rx_data` unchanged, and is not acknowledged. `buf_ovf` stays 1 until `ovf_clr` is pulsed.
- R9: While addressed, with `clk_release` at 0, the target holds SCL low once the clock line is low. Setting `clk_release` to 1 lets the clock rise.
- R10: In a read, the target holds SCL low after each acknowledge until `tx_load` has supplied a byte, which may also be loaded in advance. It shifts the byte out MSB first, changing SDA only while SCL is low. After the controller's NACK it drives SDA no more until the next start.
- R11: `evt` pulses for one cycle on each address hit, each received data byte and each transmitted data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Programmed target address |
| gc_en | input | 1 | Accept the all-zero address |
| clk_release | input | 1 | 0 holds SCL low while addressed |
| tx_load | input | 1 | Pulse: capture `tx_data` as next byte to send |
| tx_data | input | 8 | Byte to send in a read |
| rd_strobe | input | 1 | Pulse: software has read `rx_data` |
| ovf_clr | input | 1 | Pulse: clear the overflow flag |
| rx_data | output | 8 | Last accepted received byte |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| buf_ovf | output | 1 | Sticky overflow flag |
| st_data | output | 1 | Last byte was data (1) or address (0) |
| st_start | output | 1 | Start was the last bus condition |
| st_stop | output | 1 | Stop was the last bus condition |
| st_rw | output | 1 | Direction of current transfer, 1 = read |
| evt | output | 1 | One-cycle event pulse |

## Verification
The bench drives an open-drain controller model against the target. It aims at the cases that are easy to get subtly wrong. One is a byte arriving while the buffer is still full: a faulty design would overwrite `rx_data` or still acknowledge. Another is an address that matches only through general call: with the enable ignored, the target would answer address 0 always or never. The bench also checks that the direction flag is dropped on a repeated start and on the controller's NACK, which a faulty design would leave set across transfers. A further check catches clock stretching that never starts or never ends, in both the software-hold and the wait-for-transmit-byte forms. Finally, each clock the bench checks that a non-addressed target never touches SDA and that the start and stop flags never coexist.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } tgt_state_e;

  // Address comparison: own address, or all zeros when general call is enabled
  function automatic logic addr_hit(input logic [ADDR_W-1:0] got,
                                    input logic [ADDR_W-1:0] own,
                                    input logic              gc_en);
    return (got == own) || (gc_en && (got == '0));
  endfunction
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [AW-1:0] own_addr,
  input  logic          gc_en,
  input  logic          clk_release,
  input  logic          buf_full,
  input  logic          tx_load,
  input  logic [BW-1:0] tx_data,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          ev_addr,
  output logic          addr_rw,
  output logic          ev_rx,
  output logic [BW-1:0] rx_byte,
  output logic          ev_tx_end,
  output logic          ev_mnack
);
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BW - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BW);

  tgt_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [BW-1:0]    sh, tx_hold;
  logic             sda_oe_q, scl_oe_q, ack_ok, rw_q, tx_wait, tx_pend, mnack;
  logic             last_rise, engaged, consume;

  assign rx_byte   = {sh[BW-2:0], sda_s};
  assign last_rise = scl_rise && (cnt == LAST);
  assign ev_addr   = (state == ST_ADDR) && last_rise && addr_hit(sh[BW-2:0], own_addr, gc_en);
  assign addr_rw   = sda_s;
  assign ev_rx     = (state == ST_RX) && last_rise;
  assign ev_tx_end = (state == ST_TACK) && scl_rise;
  assign ev_mnack  = ev_tx_end && sda_s;
  assign engaged   = state inside {ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK};
  assign consume   = (state == ST_TX) && tx_wait && tx_pend && !start_det && !stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend <= 1'b0;
      tx_hold <= '0;
    end else if (tx_load) begin
      tx_pend <= 1'b1;
      tx_hold <= tx_data;
    end else if (consume) begin
      tx_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; sda_oe_q <= 1'b0;
      ack_ok <= 1'b0; rw_q <= 1'b0; tx_wait <= 1'b0; mnack <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR; cnt <= '0; sda_oe_q <= 1'b0; tx_wait <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; sda_oe_q <= 1'b0; tx_wait <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin sh <= rx_byte; cnt <= cnt + 1'b1; end
          if (ev_addr) begin ack_ok <= 1'b1; rw_q <= sda_s; end
          else if (last_rise) ack_ok <= 1'b0;
          if (scl_fall && cnt == FULL) begin
            if (ack_ok) begin state <= ST_AACK; sda_oe_q <= 1'b1; end
            else state <= ST_IDLE;
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_oe_q <= 1'b0; cnt <= '0; tx_wait <= rw_q;
          state <= rw_q ? ST_TX : ST_RX;
        end
        ST_RX: begin
          if (scl_rise) begin sh <= rx_byte; cnt <= cnt + 1'b1; end
          if (ev_rx) ack_ok <= !buf_full;
          if (scl_fall && cnt == FULL) begin state <= ST_RACK; sda_oe_q <= ack_ok; end
        end
        ST_RACK: if (scl_fall) begin sda_oe_q <= 1'b0; cnt <= '0; state <= ST_RX; end
        ST_TX: begin
          if (tx_wait) begin
            if (consume) begin sh <= tx_hold; sda_oe_q <= ~tx_hold[BW-1]; tx_wait <= 1'b0; end
          end else begin
            if (scl_rise) cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == FULL) begin sda_oe_q <= 1'b0; state <= ST_TACK; end
              else begin sh <= {sh[BW-2:0], 1'b0}; sda_oe_q <= ~sh[BW-2]; end
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) mnack <= sda_s;
          if (scl_fall) begin
            cnt <= '0;
            if (mnack) state <= ST_IDLE;
            else begin state <= ST_TX; tx_wait <= 1'b1; end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_oe_q <= 1'b0;
    else scl_oe_q <= engaged && !scl_s && !start_det && !stop_det &&
                     (!clk_release || ((state == ST_TX) && tx_wait && !tx_pend));
  end

  assign sda_oe = sda_oe_q;
  assign scl_oe = scl_oe_q;

  // R10
  tx_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_TX) && scl_s && $past(scl_s)) |-> $stable(sda_oe_q));

  // R3
  ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_q) |-> !scl_s);
endmodule

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status
  import i2c_tgt_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          ev_addr,
  input  logic          addr_rw,
  input  logic          ev_rx,
  input  logic [BW-1:0] rx_byte,
  input  logic          ev_tx_end,
  input  logic          ev_mnack,
  input  logic          rd_strobe,
  input  logic          ovf_clr,
  output logic [BW-1:0] rx_data,
  output logic          buf_full,
  output logic          buf_ovf,
  output logic          st_data,
  output logic          st_start,
  output logic          st_stop,
  output logic          st_rw,
  output logic          evt
);
  logic take, spill;
  assign take  = ev_rx && !buf_full;
  assign spill = ev_rx && buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; buf_full <= 1'b0; buf_ovf <= 1'b0; st_data <= 1'b0;
      st_start <= 1'b0; st_stop <= 1'b0; st_rw <= 1'b0; evt <= 1'b0;
    end else begin
      evt <= ev_addr | ev_rx | ev_tx_end;
      if (take) begin rx_data <= rx_byte; buf_full <= 1'b1; end
      else if (rd_strobe) buf_full <= 1'b0;
      if (spill) buf_ovf <= 1'b1;
      else if (ovf_clr) buf_ovf <= 1'b0;
      if (ev_addr) st_data <= 1'b0;
      else if (ev_rx || ev_tx_end) st_data <= 1'b1;
      if (start_det) begin st_start <= 1'b1; st_stop <= 1'b0; end
      else if (stop_det) begin st_stop <= 1'b1; st_start <= 1'b0; end
      if (start_det || stop_det || ev_mnack) st_rw <= 1'b0;
      else if (ev_addr) st_rw <= addr_rw;
    end
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ovf && !ovf_clr) |=> buf_ovf);

  // R8
  held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !rd_strobe) |=> $stable(rx_data));

  // R2
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_start && st_stop));

  // R6
  rw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !st_rw);
endmodule

// File: rtl/i2c_addr_target.sv
module i2c_addr_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW          = ADDR_W,
  parameter int BW          = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [AW-1:0] own_addr,
  input  logic          gc_en,
  input  logic          clk_release,
  input  logic          tx_load,
  input  logic [BW-1:0] tx_data,
  input  logic          rd_strobe,
  input  logic          ovf_clr,
  output logic [BW-1:0] rx_data,
  output logic          buf_full,
  output logic          buf_ovf,
  output logic          st_data,
  output logic          st_start,
  output logic          st_stop,
  output logic          st_rw,
  output logic          evt
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ev_addr, addr_rw, ev_rx, ev_tx_end, ev_mnack;
  logic [BW-1:0] rx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine #(.AW(AW), .BW(BW)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .gc_en(gc_en), .clk_release(clk_release), .buf_full(buf_full),
    .tx_load(tx_load), .tx_data(tx_data), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .ev_addr(ev_addr), .addr_rw(addr_rw), .ev_rx(ev_rx), .rx_byte(rx_byte),
    .ev_tx_end(ev_tx_end), .ev_mnack(ev_mnack)
  );

  i2c_tgt_status #(.BW(BW)) u_status (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .ev_addr(ev_addr), .addr_rw(addr_rw), .ev_rx(ev_rx), .rx_byte(rx_byte),
    .ev_tx_end(ev_tx_end), .ev_mnack(ev_mnack), .rd_strobe(rd_strobe), .ovf_clr(ovf_clr),
    .rx_data(rx_data), .buf_full(buf_full), .buf_ovf(buf_ovf), .st_data(st_data),
    .st_start(st_start), .st_stop(st_stop), .st_rw(st_rw), .evt(evt)
  );
endmodule

// File: tb/test_i2c_addr_target.sv
module test_i2c_addr_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe;
  logic [6:0] own_addr = 7'h5A;
  logic gc_en = 1'b0, clk_release = 1'b1, tx_load = 1'b0, rd_strobe = 1'b0, ovf_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic buf_full, buf_ovf, st_data, st_start, st_stop, st_rw, evt;

  int vec = 0, bad = 0, evt_n = 0;
  bit quiet = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_addr_target i_i2c_addr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
    .clk_release(clk_release), .tx_load(tx_load), .tx_data(tx_data),
    .rd_strobe(rd_strobe), .ovf_clr(ovf_clr), .rx_data(rx_data),
    .buf_full(buf_full), .buf_ovf(buf_ovf), .st_data(st_data),
    .st_start(st_start), .st_stop(st_stop), .st_rw(st_rw), .evt(evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock reference checks: flag exclusivity (R2) and a silent target when not addressed (R3)
  always @(negedge clk) begin
    if (evt) evt_n++;
    if (rst_n && !done) begin
      chk("R2 start/stop exclusive", {31'b0, st_start & st_stop}, 0);
      if (quiet) chk("R3 no SDA drive when unaddressed", {31'b0, sda_oe}, 0);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q);
    scl_up(); wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q);
    scl_up(); wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    m_sda = b; wt(Q);
    scl_up(); wt(Q);
    r = sda_bus;
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
    clock_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      d[i] = r;
    end
    clock_bit(~give_ack, r);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  initial begin
    logic a;
    logic [7:0] got;
    int e0;
    wt(5);
    // R1 reset state
    chk("R1 scl_oe", {31'b0, scl_oe}, 0);
    chk("R1 sda_oe", {31'b0, sda_oe}, 0);
    chk("R1 status", {24'b0, buf_full, buf_ovf, st_data, st_start, st_stop, st_rw, evt, 1'b0}, 0);
    chk("R1 rx_data", {24'b0, rx_data}, 0);
    rst_n = 1'b1; wt(5);

    // Write transfer
    bus_start();
    chk("R2 start flag", {30'b0, st_start, st_stop}, 2'b10);
    e0 = evt_n;
    write_byte({7'h5A, 1'b0}, a);
    chk("R3 own address acked", {31'b0, a}, 1);
    chk("R11 evt on address", evt_n - e0, 1);
    chk("R5 address byte", {31'b0, st_data}, 0);
    chk("R6 write direction", {31'b0, st_rw}, 0);
    write_byte(8'hC3, a);
    chk("R7 data acked", {31'b0, a}, 1);
    chk("R7 rx_data", {24'b0, rx_data}, 8'hC3);
    chk("R7 buf_full set", {31'b0, buf_full}, 1);
    chk("R5 data byte", {31'b0, st_data}, 1);
    chk("R11 evt on data", evt_n - e0, 2);
    write_byte(8'h3C, a);
    chk("R8 overflow NACK", {31'b0, a}, 0);
    chk("R8 overflow flag", {31'b0, buf_ovf}, 1);
    chk("R8 byte discarded", {24'b0, rx_data}, 8'hC3);
    pulse(rd_strobe);
    chk("R7 rd_strobe clears full", {31'b0, buf_full}, 0);
    chk("R8 overflow sticky", {31'b0, buf_ovf}, 1);
    pulse(ovf_clr);
    chk("R8 overflow cleared", {31'b0, buf_ovf}, 0);
    write_byte(8'h81, a);
    chk("R7 next byte acked", {31'b0, a}, 1);
    chk("R7 next rx_data", {24'b0, rx_data}, 8'h81);
    bus_stop();
    chk("R2 stop flag", {30'b0, st_start, st_stop}, 2'b01);
    pulse(rd_strobe);

    // Mismatching address: target stays silent
    bus_start();
    quiet = 1'b1;
    e0 = evt_n;
    write_byte({7'h11, 1'b0}, a);
    chk("R3 foreign address NACK", {31'b0, a}, 0);
    write_byte(8'hFF, a);
    chk("R3 following byte ignored", {31'b0, a}, 0);
    chk("R3 buffer untouched", {31'b0, buf_full}, 0);
    chk("R11 no evt when unaddressed", evt_n - e0, 0);
    bus_stop();

    // General call disabled, then enabled
    bus_start();
    write_byte(8'h00, a);
    chk("R4 general call off", {31'b0, a}, 0);
    bus_stop();
    quiet = 1'b0;
    gc_en = 1'b1;
    bus_start();
    e0 = evt_n;
    write_byte(8'h00, a);
    chk("R4 general call on", {31'b0, a}, 1);
    chk("R4 evt on general call", evt_n - e0, 1);
    bus_stop();
    gc_en = 1'b0;

    // Software clock hold
    bus_start();
    write_byte({7'h5A, 1'b0}, a);
    clk_release = 1'b0;
    fork
      write_byte(8'h66, a);
      begin
        wt(40);
        chk("R9 SCL held by target", {31'b0, scl_bus}, 0);
        chk("R9 controller released SCL", {31'b0, m_scl}, 1);
        clk_release = 1'b1;
      end
    join
    chk("R9 byte after release", {24'b0, rx_data}, 8'h66);
    chk("R9 byte after release acked", {31'b0, a}, 1);
    bus_stop();
    pulse(rd_strobe);

    // Read transfer with stretching until load
    bus_start();
    e0 = evt_n;
    write_byte({7'h5A, 1'b1}, a);
    chk("R3 read address acked", {31'b0, a}, 1);
    chk("R6 read direction", {31'b0, st_rw}, 1);
    fork
      read_byte(1'b1, got);
      begin
        wt(40);
        chk("R10 stretch before load", {31'b0, scl_bus}, 0);
        tx_data = 8'hA5;
        pulse(tx_load);
      end
    join
    chk("R10 first byte", {24'b0, got}, 8'hA5);
    chk("R5 sent byte", {31'b0, st_data}, 1);
    fork
      read_byte(1'b0, got);
      begin
        wt(40);
        chk("R10 stretch second byte", {31'b0, scl_bus}, 0);
        tx_data = 8'h3E;
        pulse(tx_load);
      end
    join
    chk("R10 second byte", {24'b0, got}, 8'h3E);
    chk("R11 evt per byte", evt_n - e0, 3);
    chk("R6 NACK clears direction", {31'b0, st_rw}, 0);
    read_byte(1'b0, got);
    chk("R10 silent after NACK", {24'b0, got}, 8'hFF);
    bus_stop();

    // Repeated start clears direction; preloaded transmit byte
    tx_data = 8'hFF;
    pulse(tx_load);
    bus_start();
    write_byte({7'h5A, 1'b1}, a);
    chk("R10 preload read acked", {31'b0, a}, 1);
    chk("R6 read before restart", {31'b0, st_rw}, 1);
    bus_start();
    chk("R6 repeated start clears", {31'b0, st_rw}, 0);
    chk("R2 repeated start flag", {30'b0, st_start, st_stop}, 2'b10);
    write_byte({7'h5A, 1'b0}, a);
    chk("R3 address after restart", {31'b0, a}, 1);
    chk("R5 address after restart", {31'b0, st_data}, 0);
    bus_stop();
    chk("R6 stop keeps write", {31'b0, st_rw}, 0);

    wt(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vec++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule